// File: doc/BRIEF.md
# Multi-Source Interrupt Pin Controller

The block gathers three single-cycle event inputs (watchdog expiry, alarm match and supply failure) into sticky flags. Each flag has its own enable bit, and the enabled flags share one interrupt pin. A polarity input picks the pin mode. In active-high mode the pin is driven push-pull. In active-low mode it behaves as an open-drain output: it pulls low when asserted and floats when idle. A mode input picks how long the pin stays asserted. In level mode it holds until software reads the flags. In pulse mode it asserts for a fixed number of cycles after each enabled event.

The flags byte is readable through a combinational port. A read strobe clears the sticky flags on the next edge, but an event that arrives in the cycle of the read is kept. The open-drain pin is modelled as an enable plus a data bit. A power-good input stops the push-pull pin from driving high while the supply is low. The active-low mode keeps working without power-good.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset every flag is clear and the pin is released (`irq_oe`=0).
- R2: An event sets its flag on the next edge. The flags byte places the watchdog flag in bit 7, the alarm flag in bit 6 and the supply-fail flag in bit 5. Bit 4 follows `osc_stopped` directly, and bits 3..0 read 0.
- R3: While `flags_rd` is high, `flags_q` shows the flags before clearing. The edge that ends the read clears bits 7..5.
- R4: An event coinciding with a read leaves its flag set after that edge.
- R5: In level mode (`pulse_mode`=0) the interrupt is active exactly while some flag with its enable bit set (`src_en[2]` watchdog, `src_en[1]` alarm, `src_en[0]` supply-fail) is set. A flag whose enable bit is clear has no effect on the pin.
- R6: In pulse mode an enabled event makes the interrupt active for exactly PULSE_W cycles, starting after the event's edge. A new enabled event restarts the full window.
- R7: With `pol_hi`=1 and `pwr_good`=1, the block drives the pin (`irq_oe`=1) and `irq_out` equals the interrupt state.
- R8: With `pol_hi`=1 and `pwr_good`=0, the pin is released (`irq_oe`=0).
- R9: With `pol_hi`=0, an active interrupt gives `irq_oe`=1 and `irq_out`=0, and an idle one gives `irq_oe`=0. `pwr_good` has no effect in this mode.
- R10: In pulse mode, an event whose enable bit is clear starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_evt | input | 1 | Watchdog expiry event, one cycle |
| alm_evt | input | 1 | Alarm match event, one cycle |
| pfail_evt | input | 1 | Supply failure event, one cycle |
| osc_stopped | input | 1 | Oscillator-stopped status, shown in bit 4 |
| src_en | input | 3 | Source enables {watchdog, alarm, supply-fail} |
| pol_hi | input | 1 | 1: active-high push-pull, 0: active-low open-drain |
| pulse_mode | input | 1 | 1: pulse of PULSE_W cycles, 0: level until read |
| pwr_good | input | 1 | Supply above switch threshold |
| flags_rd | input | 1 | Flags read strobe |
| flags_q | output | 8 | Flags byte |
| irq_oe | output | 1 | Pin driver enable |
| irq_out | output | 1 | Pin driver value |

## Verification
The bench builds the block with PULSE_W=5. This value is larger than the default, so an off-by-one pulse length shows as a count mismatch. It also leaves room to retrigger the pulse in the middle of its window. The short window keeps the clear-on-read and event-collision cases reachable within a few cycles, under every combination of polarity and power-good.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 3;
  localparam int SRC_PF  = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_WDT = 2;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drv_t;

  // Pin driver for an interrupt state under the chosen mode
  function automatic pin_drv_t pin_drive(input logic active, input logic pol_hi,
                                         input logic pwr_good);
    pin_drv_t d;
    if (pol_hi) begin
      d.oe  = pwr_good;
      d.val = pwr_good & active;
    end else begin
      d.oe  = active;
      d.val = 1'b0;
    end
    return d;
  endfunction

  function automatic logic [7:0] pack_flags(input logic [NSRC-1:0] f, input logic osc);
    return {f[SRC_WDT], f[SRC_ALM], f[SRC_PF], osc, 4'b0000};
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (rd)     flag[i] <= 1'b0;
    end

    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);
    a_r3_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !evt[i]) |=> !flag[i]);
    a_r4_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && evt[i]) |=> flag[i]);
  end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (trig)      cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt == LOAD));
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && busy) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_evt,
  input  logic       alm_evt,
  input  logic       pfail_evt,
  input  logic       osc_stopped,
  input  logic [2:0] src_en,
  input  logic       pol_hi,
  input  logic       pulse_mode,
  input  logic       pwr_good,
  input  logic       flags_rd,
  output logic [7:0] flags_q,
  output logic       irq_oe,
  output logic       irq_out
);
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] flag_vec;
  logic            evt_armed;    // an enabled event this cycle
  logic            level_req;    // an enabled flag is set
  logic            pulse_busy;
  logic            irq_active;
  pin_drv_t        drv;

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_WDT] = wdt_evt;
    evt_vec[SRC_ALM] = alm_evt;
    evt_vec[SRC_PF]  = pfail_evt;
  end

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .rd(flags_rd), .flag(flag_vec)
  );

  assign evt_armed = |(evt_vec & src_en);
  assign level_req = |(flag_vec & src_en);

  irq_pulse_timer #(.PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(evt_armed), .busy(pulse_busy)
  );

  assign irq_active = pulse_mode ? pulse_busy : level_req;
  assign drv        = pin_drive(irq_active, pol_hi, pwr_good);
  assign irq_oe     = drv.oe;
  assign irq_out    = drv.val;
  assign flags_q    = pack_flags(flag_vec, osc_stopped);

  a_r8_no_drive_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_hi && !pwr_good) |-> !irq_oe);
  a_r9_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_hi |-> !(irq_oe && irq_out));
  a_r10_masked_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !pulse_busy && !evt_armed) |=> !pulse_busy);
  a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && pol_hi && pwr_good) |-> (irq_out == level_req));
endmodule

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;
  localparam int PW = 5;

  logic clk = 0, rst_n = 0;
  logic wdt_evt = 0, alm_evt = 0, pfail_evt = 0, osc_stopped = 0;
  logic [2:0] src_en = 3'b000;
  logic pol_hi = 0, pulse_mode = 0, pwr_good = 1, flags_rd = 0;
  logic [7:0] flags_q;
  logic irq_oe, irq_out;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  irq_pin_ctrl #(.PULSE_W(PW)) i_irq_pin_ctrl (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();  // advance one edge, then settle
    @(posedge clk); #1;
  endtask

  task automatic fire(input logic w, input logic a, input logic p, input logic rd);
    @(negedge clk);
    wdt_evt = w; alm_evt = a; pfail_evt = p; flags_rd = rd;
    step();
    wdt_evt = 0; alm_evt = 0; pfail_evt = 0; flags_rd = 0;
  endtask

  task automatic clear_all();
    fire(0, 0, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 flags", flags_q, 8'h00);
    chk("R1 oe", {7'b0, irq_oe}, 8'h00);
  endtask

  task automatic t_flags();
    fire(1, 0, 0, 0); chk("R2 wdt bit7", flags_q, 8'h80);
    fire(0, 1, 0, 0); chk("R2 alm bit6", flags_q, 8'hC0);
    fire(0, 0, 1, 0); chk("R2 pf bit5", flags_q, 8'hE0);
    @(negedge clk); osc_stopped = 1; #1;
    chk("R2 osc bit4", flags_q, 8'hF0);
    flags_rd = 1; #1;
    chk("R3 read shows old", flags_q, 8'hF0);
    step(); flags_rd = 0;
    chk("R3 cleared", flags_q, 8'h10);
    @(negedge clk); osc_stopped = 0;
  endtask

  task automatic t_collide();
    fire(0, 1, 0, 0);
    fire(1, 0, 0, 1);
    chk("R4 evt during read kept", flags_q, 8'h80);
    clear_all();
    chk("R3 clear after collide", flags_q, 8'h00);
  endtask

  task automatic t_level();
    @(negedge clk); pulse_mode = 0; pol_hi = 1; pwr_good = 1; src_en = 3'b010;
    fire(1, 0, 0, 0);
    chk("R5 masked wdt idle", {7'b0, irq_out}, 8'h00);
    fire(0, 1, 0, 0);
    chk("R5 alm active", {7'b0, irq_out}, 8'h01);
    step(); step();
    chk("R5 level holds", {7'b0, irq_out}, 8'h01);
    clear_all();
    chk("R5 read releases", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_pulse();
    @(negedge clk); pulse_mode = 1; pol_hi = 1; pwr_good = 1; src_en = 3'b110;
    fire(0, 0, 1, 0);
    chk("R10 masked pf flag", flags_q, 8'h20);
    chk("R10 no pulse", {7'b0, irq_out}, 8'h00);
    step();
    chk("R10 still no pulse", {7'b0, irq_out}, 8'h00);
    clear_all();
    fire(1, 0, 0, 0);
    for (int i = 0; i < PW; i++) begin
      chk("R6 pulse active", {7'b0, irq_out}, 8'h01);
      if (i < PW - 1) step();
    end
    step();
    chk("R6 pulse ends", {7'b0, irq_out}, 8'h00);
    fire(0, 1, 0, 0);
    step(); step();
    fire(0, 1, 0, 0);  // retrigger
    for (int i = 0; i < PW; i++) begin
      chk("R6 retrigger active", {7'b0, irq_out}, 8'h01);
      if (i < PW - 1) step();
    end
    step();
    chk("R6 retrigger ends", {7'b0, irq_out}, 8'h00);
    clear_all();
  endtask

  task automatic t_drive();
    @(negedge clk); pulse_mode = 0; pol_hi = 1; pwr_good = 1; src_en = 3'b111;
    #1;
    chk("R7 idle driven low", {6'b0, irq_oe, irq_out}, 8'h02);
    fire(0, 1, 0, 0);
    chk("R7 active driven high", {6'b0, irq_oe, irq_out}, 8'h03);
    @(negedge clk); pwr_good = 0; #1;
    chk("R8 released unpowered", {7'b0, irq_oe}, 8'h00);
    @(negedge clk); pol_hi = 0; pwr_good = 1; #1;
    chk("R9 od active pulls low", {6'b0, irq_oe, irq_out}, 8'h02);
    @(negedge clk); pwr_good = 0; #1;
    chk("R9 od kept unpowered", {6'b0, irq_oe, irq_out}, 8'h02);
    clear_all();
    chk("R9 od idle floats", {7'b0, irq_oe}, 8'h00);
    @(negedge clk); pwr_good = 1;
  endtask

  initial begin
    #1; t_reset();
    #12; rst_n = 1;
    step();
    t_reset();
    t_flags();
    t_collide();
    t_level();
    t_pulse();
    t_drive();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule